// File: doc/BRIEF.md
# Chained Converter Serial Read Sequencer

This block sits on the host side of a row of successive-approximation converters that are wired in series. The converters share one conversion-start line, one chip select and one serial clock, and only the last one in the row returns data to the host. When a request arrives, the sequencer raises the conversion start for a fixed number of clock cycles so that every converter samples at the same instant. It then waits for the shared busy line to go high and come back low. After that it opens chip select and read, and it produces a serial clock in bursts whose rate is set by a divider value.

The incoming bitstream holds one 16-bit word per converter, most significant bit first. The converter nearest the host sends its word first, and each converter further up the row sends its word straight after, with no gap. The sequencer shifts in all of the bits and sorts them into a parallel array of words. It then releases chip select and raises a one-cycle valid strobe. The serial clock stays low between reads. It is never allowed to move while a conversion is running, so the converters' bit decisions are not disturbed by switching noise.

Top module: `chain_adc_reader`

## Requirements
- R1: While rst_n is low at a clock edge, and after the reset is released, cs_n_o and rd_n_o are 1, and sclk_o, cnvst_o and valid_o are 0.
- R2: When start_i is seen high in the idle state, cnvst_o goes high for exactly CNV_CYC consecutive clock cycles. While cnvst_o is high, cs_n_o and rd_n_o stay high.
- R3: cs_n_o and rd_n_o go low only after busy_i has been seen high and then low. sclk_o never changes while busy_i is high.
- R4: Each read produces exactly 16·N_DEV rising edges on sclk_o. Each high phase lasts div+1 clock cycles, and each low phase between two pulses also lasts div+1 clock cycles. Here div is the value of div_i captured in the cycle start_i is accepted, so later changes to div_i have no effect on that read.
- R5: sdata_i is sampled when sclk_o rises. The first 16 bits received form words_o[0] with the most significant bit first, the next 16 bits form words_o[1], and so on.
- R6: valid_o is high for exactly one cycle. In that cycle cs_n_o and rd_n_o are back at 1 and words_o holds the new result. words_o does not change at any other time.
- R7: A start_i pulse given while a read sequence is in progress is ignored. It causes no additional cnvst_o pulse.
- R8: While cs_n_o is high, sclk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion and read |
| div_i | input | DIV_W | Serial clock half-period, minus one, in clk cycles |
| busy_i | input | 1 | Shared converter busy line |
| sdata_i | input | 1 | Serial data from the converter nearest the host |
| cnvst_o | output | 1 | Shared conversion start |
| cs_n_o | output | 1 | Shared chip select, active low |
| rd_n_o | output | 1 | Shared read enable, active low |
| sclk_o | output | 1 | Shared serial clock, low when idle |
| words_o | output | N_DEV×WORD_W | Result words; index 0 is the converter nearest the host |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with three chained converters, a four-cycle start pulse and a 4-bit divider. Having three words means a middle word sits between two word boundaries, so the ordering is tested on both sides of it. The 4-bit divider makes both the fastest setting (zero) and the slowest one (fifteen) short enough to run several times. A model of the converter row varies the busy length and changes the divider input and start_i during each read, so the captured divider value and the ignoring of repeated starts are both tested.

// File: rtl/chain_rd_pkg.sv
// Shared state type for the chained converter read sequencer.
package chain_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_SHIFT,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/sclk_gen.sv
// Serial clock generator.
// Makes a clock whose phases each last half_i+1 cycles while en is high, and
// holds it low with the counter cleared while en is low. Flags the cycle
// before each rising and each falling edge.
// Assumes half_i stays constant while en is high.
module sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt;
    logic             sclk_q;
    logic             term;

    // Phase end detection and edge flags.
    always_comb begin
        term   = (cnt == half_i);
        rise_o = en && term && !sclk_q;
        fall_o = en && term && sclk_q;
    end

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (term) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
endmodule

// File: rtl/read_seq.sv
// Read sequencer.
// Steps through start pulse, busy high, busy low, shift burst and done.
// Counts the sampled bits and signals when the result words are to be loaded.
// Assumes busy_i is synchronous to clk and rises after the start pulse.
module read_seq
    import chain_rd_pkg::*;
#(
    parameter int N_BITS  = 32,
    parameter int CNV_CYC = 2,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             busy_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic [DIV_W-1:0] half_o,
    output logic             cnvst_o,
    output logic             sel_n_o,
    output logic             shift_en_o,
    output logic             load_o,
    output logic             valid_o
);
    localparam int BCNT_W = $clog2(N_BITS + 1);
    localparam int CCNT_W = $clog2(CNV_CYC + 1);

    rd_state_t         state;
    logic [BCNT_W-1:0] bit_cnt;
    logic [CCNT_W-1:0] cnv_cnt;
    logic [DIV_W-1:0]  div_q;
    logic              last_fall;

    // Final falling edge of the burst.
    always_comb last_fall = (state == ST_SHIFT) && fall_i
                            && (bit_cnt == BCNT_W'(N_BITS));

    // State, counters and captured divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            cnv_cnt <= '0;
            div_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    state   <= ST_CONV;
                    cnv_cnt <= '0;
                    div_q   <= div_i;
                end
                ST_CONV: begin
                    cnv_cnt <= cnv_cnt + 1'b1;
                    if (cnv_cnt == CCNT_W'(CNV_CYC - 1)) state <= ST_WAIT_HI;
                end
                ST_WAIT_HI: if (busy_i) state <= ST_WAIT_LO;
                ST_WAIT_LO: if (!busy_i) begin
                    state   <= ST_SHIFT;
                    bit_cnt <= '0;
                end
                ST_SHIFT: begin
                    if (rise_i) bit_cnt <= bit_cnt + 1'b1;
                    if (last_fall) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        half_o     = div_q;
        cnvst_o    = (state == ST_CONV);
        sel_n_o    = (state != ST_SHIFT);
        shift_en_o = (state == ST_SHIFT);
        load_o     = last_fall;
        valid_o    = (state == ST_DONE);
    end
endmodule

// File: rtl/chain_shifter.sv
// Deserialiser.
// Shifts in one bit per sampling flag and loads the collected stream into a
// held word array on load_i. The first bit received ends up as the most
// significant bit of word 0.
module chain_shifter #(
    parameter int N_DEV  = 2,
    parameter int WORD_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_i,
    input  logic                         sdata_i,
    input  logic                         load_i,
    output logic [N_DEV-1:0][WORD_W-1:0] words_o
);
    localparam int TOT = N_DEV * WORD_W;

    logic [TOT-1:0] sr;

    // Serial to parallel shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (cap_i) sr <= {sr[TOT-2:0], sdata_i};
    end

    for (genvar k = 0; k < N_DEV; k++) begin : g_word
        // Hold register for word k.
        always_ff @(posedge clk) begin
            if (!rst_n)      words_o[k] <= '0;
            else if (load_i) words_o[k] <= sr[TOT-1-k*WORD_W -: WORD_W];
        end
    end
endmodule

// File: rtl/chain_adc_reader.sv
// Top level of the chained converter read controller.
// Starts a shared conversion, waits for it to finish, then reads N_DEV words
// over a divided serial clock and presents them together with a one-cycle
// strobe. Assumes all inputs are synchronous to clk.
module chain_adc_reader #(
    parameter int N_DEV   = 2,
    parameter int WORD_W  = 16,
    parameter int DIV_W   = 8,
    parameter int CNV_CYC = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [DIV_W-1:0]             div_i,
    input  logic                         busy_i,
    input  logic                         sdata_i,
    output logic                         cnvst_o,
    output logic                         cs_n_o,
    output logic                         rd_n_o,
    output logic                         sclk_o,
    output logic [N_DEV-1:0][WORD_W-1:0] words_o,
    output logic                         valid_o
);
    localparam int N_BITS = N_DEV * WORD_W;

    logic [DIV_W-1:0] half;
    logic             rise, fall, shift_en, load, sel_n;

    read_seq #(.N_BITS(N_BITS), .CNV_CYC(CNV_CYC), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
        .div_i(div_i), .rise_i(rise), .fall_i(fall), .half_o(half),
        .cnvst_o(cnvst_o), .sel_n_o(sel_n), .shift_en_o(shift_en),
        .load_o(load), .valid_o(valid_o)
    );

    sclk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .half_i(half),
        .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
    );

    chain_shifter #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cap_i(rise), .sdata_i(sdata_i),
        .load_i(load), .words_o(words_o)
    );

    assign cs_n_o = sel_n;
    assign rd_n_o = sel_n;
endmodule

// File: rtl/chain_adc_reader_chk.sv
// Protocol checker for chain_adc_reader, attached through bind.
module chain_adc_reader_chk #(
    parameter int N_DEV  = 2,
    parameter int WORD_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy_i,
    input logic                         cnvst_o,
    input logic                         cs_n_o,
    input logic                         rd_n_o,
    input logic                         sclk_o,
    input logic                         valid_o,
    input logic [N_DEV-1:0][WORD_W-1:0] words_o
);
    assert_sclk_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    assert_quiet_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (cs_n_o && rd_n_o && !sclk_o));

    assert_cnv_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> (cs_n_o && rd_n_o));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(words_o));

    assert_valid_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && rd_n_o));
endmodule

bind chain_adc_reader chain_adc_reader_chk #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .cnvst_o(cnvst_o),
    .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .sclk_o(sclk_o), .valid_o(valid_o),
    .words_o(words_o)
);

// File: tb/chain_adc_reader_test.sv
module chain_adc_reader_test;
    localparam int N_DEV = 3, WORD_W = 16, DIV_W = 4, CNV_CYC = 4;
    localparam int TOT = N_DEV * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic busy_i = 1'b0;
    logic sdata_i = 1'b0;
    logic cnvst_o, cs_n_o, rd_n_o, sclk_o, valid_o;
    logic [N_DEV-1:0][WORD_W-1:0] words_o;

    always #2.5 clk = ~clk;

    chain_adc_reader #(.N_DEV(N_DEV), .WORD_W(WORD_W), .DIV_W(DIV_W), .CNV_CYC(CNV_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i), .busy_i(busy_i),
        .sdata_i(sdata_i), .cnvst_o(cnvst_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
        .sclk_o(sclk_o), .words_o(words_o), .valid_o(valid_o)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // converter row model state
    logic [TOT-1:0] stream = '0;
    int busy_len = 3, busy_left = 0, cur_div = 0;
    int cnv_run = 0, cnv_w = 0, cnv_pulses = 0;
    int bitidx = 0, rise_cnt = 0, hi_run = 0, lo_run = 0;
    int hi_err = 0, lo_err = 0, busy_err = 0, park_err = 0, valid_cnt = 0;
    logic sclk_prev = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] exp_word(input logic [TOT-1:0] s, input int k);
        return s[TOT-1-k*WORD_W -: WORD_W];
    endfunction

    // Converter row model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cnvst_o) cnv_run++;
            else if (cnv_run > 0) begin
                cnv_w = cnv_run; cnv_pulses++; cnv_run = 0;
                busy_i = 1'b1; busy_left = busy_len;
            end else if (busy_i) begin
                if (busy_left == 0) busy_i = 1'b0; else busy_left--;
            end
            if (busy_i && (sclk_o != sclk_prev)) busy_err++;
            if (cs_n_o && sclk_o) park_err++;
            if (sclk_o && !sclk_prev) begin
                rise_cnt++;
                if (lo_run > 0 && lo_run != cur_div + 1) lo_err++;
                lo_run = 0;
            end
            if (sclk_o) hi_run++;
            else begin
                if (hi_run > 0) begin
                    if (hi_run != cur_div + 1) hi_err++;
                    hi_run = 0;
                    bitidx++;
                end
                if (!cs_n_o && rise_cnt > 0) lo_run++;
            end
            if (cs_n_o) bitidx = 0;
            sdata_i = (bitidx < TOT) ? stream[TOT-1-bitidx] : 1'b0;
            if (valid_o) valid_cnt++;
            sclk_prev = sclk_o;
        end
    end

    task automatic do_read(input int d, input logic [TOT-1:0] s, input int blen);
        int wait_cyc;
        logic [N_DEV-1:0][WORD_W-1:0] held;
        @(negedge clk);
        stream = s; busy_len = blen; cur_div = d;
        rise_cnt = 0; cnv_pulses = 0; hi_err = 0; lo_err = 0; valid_cnt = 0;
        div_i = DIV_W'(d); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        div_i = DIV_W'(d + 1 + ($urandom % 3));   // must not affect this read (R4)
        repeat (2) @(negedge clk);
        start_i = 1'b1;                             // ignored start (R7)
        @(negedge clk);
        start_i = 1'b0;
        wait_cyc = 0;
        while (!valid_o && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
            if (wait_cyc == 40) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
        end
        check(valid_o == 1'b1, "R6", "valid seen", valid_o, 1);
        check(cs_n_o && rd_n_o, "R6", "select released at valid", {cs_n_o, rd_n_o}, 3);
        for (int k = 0; k < N_DEV; k++)
            check(words_o[k] == exp_word(s, k), "R5", $sformatf("word %0d", k),
                  words_o[k], exp_word(s, k));
        check(rise_cnt == TOT, "R4", "rising edge count", rise_cnt, TOT);
        check(hi_err == 0 && lo_err == 0, "R4", "phase length errors", hi_err + lo_err, 0);
        check(cnv_w == CNV_CYC, "R2", "start pulse width", cnv_w, CNV_CYC);
        check(cnv_pulses == 1, "R7", "start pulses per read", cnv_pulses, 1);
        held = words_o;
        repeat (3) @(negedge clk);
        check(valid_cnt == 1, "R6", "valid cycles", valid_cnt, 1);
        check(words_o == held, "R6", "words held", 0, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0] s;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1: reset state
        check(cs_n_o && rd_n_o, "R1", "select during reset", {cs_n_o, rd_n_o}, 3);
        check(!sclk_o && !cnvst_o && !valid_o, "R1", "idle lines during reset",
              {sclk_o, cnvst_o, valid_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n_o && !sclk_o && !cnvst_o && !valid_o, "R1", "idle after reset",
              {cs_n_o, sclk_o, cnvst_o, valid_o}, 8);

        // directed corners
        do_read(0, {TOT{1'b1}}, 2);
        do_read(0, {16'h8001, 16'h7FFE, 16'hA5C3}, 0);
        do_read(15, {16'hAAAA, 16'h5555, 16'h0F0F}, 6);
        do_read(1, '0, 1);
        // random
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < N_DEV; k++) s[k*WORD_W +: WORD_W] = WORD_W'($urandom);
            do_read($urandom % 4, s, $urandom % 12);
        end

        check(busy_err == 0, "R3", "sclk moves while busy", busy_err, 0);
        check(park_err == 0, "R8", "sclk high while deselected", park_err, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule